// File: doc/BRIEF.md
# PCI Configuration Space Register File

This block is the 256-byte configuration space of one PCI function. A host reaches it with a byte address, a length of 1, 2 or 4 bytes, a 32-bit data word, and separate read and write strobes. Every byte is stored through its own writable-bit mask, so a write can change only the bits that are permitted to change. The masks and reset contents come from parameters. These parameters set the identity fields, the size and type code of each base address register, the expansion ROM size, and whether the function is a plain endpoint or a bridge.

Writes are merged byte by byte, little-endian, as `(old & ~mask) | (data & mask)`. After each write the block compares the space before and after the write. It raises a one-cycle remap pulse when any base address byte changed, or when the I/O or memory decode enable toggled. Software decoding of the address is not needed for this. In bridge mode the stored secondary bus number is driven out on a port. Reads return the requested bytes on the next clock.

Top module: `cfg_space_regfile`

## Requirements
- R1: The space holds 256 bytes. Every bit of offsets 0x40 to 0xFF is writable and resets to zero.
- R2: A write of length n (1, 2 or 4) at address A sets byte A+i, for each i < n, to `(old & ~mask) | (wdata[8i+7:8i] & mask)`. Lanes that would land above 0xFF are dropped.
- R3: Offsets 0x0C and 0x3C are fully writable. Byte 0x04 has only bits [2:0] writable, and byte 0x05 is read-only. Every other header byte that R4 to R6 and R10 do not cover is read-only and zero.
- R4: The following identity fields are loaded from parameters at reset and never change: vendor ID (0x00 to 0x01), device ID (0x02 to 0x03), revision (0x08), class code (0x09 to 0x0B), interrupt pin (0x3D), and header type (0x0E, 0x00 for an endpoint and 0x01 for a bridge).
- R5: Base register n sits at 0x10+4n. With size 2^k (k > 0), its 32-bit mask is ~(2^k-1) and bits [3:0] reset to its type code and stay there. With k = 0 the register is absent and reads as zero.
- R6: The ROM base register sits at 0x30 (0x38 in bridge mode). Its mask is ~(2^k-1) | 1, so the enable bit 0 is also writable.
- R7: A one-byte write to one byte of a base register changes that byte alone, under that byte's mask.
- R8: In the cycle after a write, `remap` is 1 exactly when some byte in 0x10 to 0x27 differs from its value before the write, or when bit 0 or bit 1 of byte 0x04 toggled. Otherwise `remap` is 0, including after a write that changes nothing.
- R9: A read of length n at address A loads `rdata` on the next clock with byte A+i in bits [8i+7:8i] for i < n. Unrequested lanes and lanes above 0xFF read as zero. `rdata` holds when there is no read.
- R10: In bridge mode, base registers 2 to 5 are absent, bytes 0x18 to 0x1A are fully writable, and `sec_bus` equals stored byte 0x19 after each write. In endpoint mode `sec_bus` is 0.
- R11: A synchronous active-high reset restores every byte to its reset value and clears `rdata` and `remap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe, never together with wr_en |
| addr | input | 8 | Byte address of the first lane |
| len | input | 3 | Access length in bytes: 1, 2 or 4 |
| wdata | input | 32 | Write data, lane 0 in bits [7:0] |
| rdata | output | 32 | Read data, valid from the clock after rd_en |
| remap | output | 1 | One-cycle pulse: decode-relevant contents changed |
| sec_bus | output | 8 | Secondary bus number (bridge mode), else 0 |

## Verification
The masked byte merge and the remap comparison act on the same write in the same cycle, so the pulse depends on what the mask let through, not on which address was hit. The bench provokes this in three ways. It rewrites a base register with a value its mask reduces to the stored one. It flips the bus-master bit, which is writable but carries no decode meaning. It uses four-byte writes that straddle the command, status or header-type bytes and the first base register, including writes that run past 0xFF. A reference image with masks derived from the requirements predicts both the new bytes and the pulse for every write, and the pulse is sampled in the cycle after the strobe together with the read-back contents.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int unsigned CFG_BYTES = 256;
    localparam int unsigned HDR_BYTES = 64;
    localparam int unsigned NUM_BARS  = 6;
    localparam int unsigned LANES     = 4;
    localparam int unsigned LOG2_W    = 6;
    localparam int unsigned TYPE_W    = 4;

    typedef logic [CFG_BYTES-1:0][7:0] cfg_image_t;

    localparam int unsigned OFS_VENDOR   = 'h00;
    localparam int unsigned OFS_DEVICE   = 'h02;
    localparam int unsigned OFS_CMD      = 'h04;
    localparam int unsigned OFS_REV      = 'h08;
    localparam int unsigned OFS_CLASS    = 'h09;
    localparam int unsigned OFS_LINESZ   = 'h0C;
    localparam int unsigned OFS_HTYPE    = 'h0E;
    localparam int unsigned OFS_BAR0     = 'h10;
    localparam int unsigned OFS_BAR_LAST = 'h27;
    localparam int unsigned OFS_BUSNUM   = 'h18;
    localparam int unsigned OFS_SECBUS   = 'h19;
    localparam int unsigned OFS_SUBBUS   = 'h1A;
    localparam int unsigned OFS_ROM_EP   = 'h30;
    localparam int unsigned OFS_ROM_BR   = 'h38;
    localparam int unsigned OFS_INTLINE  = 'h3C;
    localparam int unsigned OFS_INTPIN   = 'h3D;

    localparam logic [7:0] CMD_WR_BITS  = 8'h07;
    localparam logic [7:0] CMD_DEC_BITS = 8'h03;
    localparam logic [7:0] HTYPE_EP     = 8'h00;
    localparam logic [7:0] HTYPE_BR     = 8'h01;

    // Writable bits of a naturally aligned region of 2**log2sz bytes.
    function automatic logic [31:0] region_mask(input int unsigned log2sz, input logic rom);
        logic [31:0] m;
        if (log2sz == 0) begin
            m = '0;
        end else begin
            m = 32'hFFFF_FFFF << log2sz;
            if (rom) m = m | 32'h1;
        end
        return m;
    endfunction

endpackage

// File: rtl/cfg_layout.sv
module cfg_layout
    import cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'hA5C3,
    parameter logic [15:0] DEVICE_ID = 16'h0102,
    parameter logic [7:0]  REVISION  = 8'h07,
    parameter logic [23:0] CLASS     = 24'h028000,
    parameter logic [7:0]  INT_PIN   = 8'h01,
    parameter logic [NUM_BARS*LOG2_W-1:0] BAR_LOG2 = {6'd0, 6'd0, 6'd0, 6'd20, 6'd12, 6'd5},
    parameter logic [NUM_BARS*TYPE_W-1:0] BAR_TYPE = {4'h0, 4'h0, 4'h0, 4'h8, 4'h0, 4'h1},
    parameter int unsigned ROM_LOG2 = 11,
    parameter bit          BRIDGE   = 1'b0
) (
    output cfg_image_t mask_o,
    output cfg_image_t init_o
);

    localparam int unsigned ROM_BASE = BRIDGE ? OFS_ROM_BR : OFS_ROM_EP;
    localparam int unsigned BARS_ON  = BRIDGE ? 2 : NUM_BARS;

    // Returns {mask, reset value} of one byte offset.
    function automatic logic [15:0] byte_attr(input int unsigned a);
        logic [7:0]  m;
        logic [7:0]  v;
        logic [31:0] wide;
        int unsigned bar;
        int unsigned lane;
        int unsigned lg;
        m = 8'h00;
        v = 8'h00;
        if (a >= HDR_BYTES) begin
            m = 8'hFF;
        end else begin
            if (a == OFS_VENDOR)     v = VENDOR_ID[7:0];
            if (a == OFS_VENDOR + 1) v = VENDOR_ID[15:8];
            if (a == OFS_DEVICE)     v = DEVICE_ID[7:0];
            if (a == OFS_DEVICE + 1) v = DEVICE_ID[15:8];
            if (a == OFS_REV)        v = REVISION;
            if (a == OFS_CLASS)      v = CLASS[7:0];
            if (a == OFS_CLASS + 1)  v = CLASS[15:8];
            if (a == OFS_CLASS + 2)  v = CLASS[23:16];
            if (a == OFS_HTYPE)      v = BRIDGE ? HTYPE_BR : HTYPE_EP;
            if (a == OFS_INTPIN)     v = INT_PIN;
            if (a == OFS_CMD)        m = CMD_WR_BITS;
            if (a == OFS_LINESZ)     m = 8'hFF;
            if (a == OFS_INTLINE)    m = 8'hFF;
            if (a >= OFS_BAR0 && a <= OFS_BAR_LAST) begin
                bar  = (a - OFS_BAR0) / 4;
                lane = (a - OFS_BAR0) % 4;
                if (bar < BARS_ON) begin
                    lg   = int'(BAR_LOG2[bar*LOG2_W +: LOG2_W]);
                    wide = region_mask(lg, 1'b0);
                    m    = wide[lane*8 +: 8];
                    if (lane == 0 && lg != 0) v = {4'h0, BAR_TYPE[bar*TYPE_W +: TYPE_W]};
                end else if (a >= OFS_BUSNUM && a <= OFS_SUBBUS) begin
                    m = 8'hFF;
                end
            end
            if (a >= ROM_BASE && a < ROM_BASE + 4) begin
                wide = region_mask(ROM_LOG2, 1'b1);
                m    = wide[(a - ROM_BASE)*8 +: 8];
            end
        end
        return {m, v};
    endfunction

    for (genvar a = 0; a < CFG_BYTES; a++) begin : g_byte
        localparam logic [15:0] ATTR = byte_attr(a);
        assign mask_o[a] = ATTR[15:8];
        assign init_o[a] = ATTR[7:0];
    end

endmodule

// File: rtl/cfg_write_merge.sv
module cfg_write_merge
    import cfg_pkg::*;
(
    input  logic        wr_en,
    input  logic [7:0]  addr,
    input  logic [2:0]  len,
    input  logic [31:0] wdata,
    input  cfg_image_t  cur_i,
    input  cfg_image_t  mask_i,
    output cfg_image_t  nxt_o,
    output logic        change_o
);

    localparam int unsigned BAR_LO = OFS_BAR0;
    localparam int unsigned BAR_HI = OFS_BAR_LAST;

    logic [8:0] idx [LANES];

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            idx[i] = {1'b0, addr} + 9'(i);
        end
    end

    always_comb begin
        nxt_o = cur_i;
        if (wr_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (3'(i) < len && !idx[i][8]) begin
                    nxt_o[idx[i][7:0]] = (cur_i[idx[i][7:0]] & ~mask_i[idx[i][7:0]])
                                       | (wdata[8*i +: 8] & mask_i[idx[i][7:0]]);
                end
            end
        end
    end

    logic bar_diff;
    logic dec_diff;

    always_comb begin
        bar_diff = (nxt_o[BAR_HI:BAR_LO] != cur_i[BAR_HI:BAR_LO]);
        dec_diff = |((nxt_o[OFS_CMD] ^ cur_i[OFS_CMD]) & CMD_DEC_BITS);
        change_o = wr_en & (bar_diff | dec_diff);
    end

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfg_pkg::*;
(
    input  logic [7:0]  addr,
    input  logic [2:0]  len,
    input  cfg_image_t  image_i,
    output logic [31:0] word_o
);

    always_comb begin
        word_o = '0;
        for (int i = 0; i < LANES; i++) begin
            if (3'(i) < len && ({1'b0, addr} + 9'(i)) < 9'(CFG_BYTES)) begin
                word_o[8*i +: 8] = image_i[8'(addr + 8'(i))];
            end
        end
    end

endmodule

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile
    import cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'hA5C3,
    parameter logic [15:0] DEVICE_ID = 16'h0102,
    parameter logic [7:0]  REVISION  = 8'h07,
    parameter logic [23:0] CLASS     = 24'h028000,
    parameter logic [7:0]  INT_PIN   = 8'h01,
    parameter logic [NUM_BARS*LOG2_W-1:0] BAR_LOG2 = {6'd0, 6'd0, 6'd0, 6'd20, 6'd12, 6'd5},
    parameter logic [NUM_BARS*TYPE_W-1:0] BAR_TYPE = {4'h0, 4'h0, 4'h0, 4'h8, 4'h0, 4'h1},
    parameter int unsigned ROM_LOG2 = 11,
    parameter bit          BRIDGE   = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  addr,
    input  logic [2:0]  len,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        remap,
    output logic [7:0]  sec_bus
);

    typedef struct packed {
        cfg_image_t  image;
        logic [31:0] rdata;
        logic        remap;
    } state_t;

    state_t      state_d, state_q;
    cfg_image_t  mask_w, init_w, merged_w, image_q;
    logic        change_w;
    logic [31:0] rword_w;

    cfg_layout #(
        .VENDOR_ID (VENDOR_ID),
        .DEVICE_ID (DEVICE_ID),
        .REVISION  (REVISION),
        .CLASS     (CLASS),
        .INT_PIN   (INT_PIN),
        .BAR_LOG2  (BAR_LOG2),
        .BAR_TYPE  (BAR_TYPE),
        .ROM_LOG2  (ROM_LOG2),
        .BRIDGE    (BRIDGE)
    ) u_layout (
        .mask_o (mask_w),
        .init_o (init_w)
    );

    cfg_write_merge u_merge (
        .wr_en    (wr_en),
        .addr     (addr),
        .len      (len),
        .wdata    (wdata),
        .cur_i    (state_q.image),
        .mask_i   (mask_w),
        .nxt_o    (merged_w),
        .change_o (change_w)
    );

    cfg_read_mux u_rmux (
        .addr    (addr),
        .len     (len),
        .image_i (state_q.image),
        .word_o  (rword_w)
    );

    always_comb begin
        state_d       = state_q;
        state_d.image = merged_w;
        state_d.remap = change_w;
        if (rd_en) state_d.rdata = rword_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.image <= init_w;
            state_q.rdata <= '0;
            state_q.remap <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign image_q = state_q.image;
    assign rdata   = state_q.rdata;
    assign remap   = state_q.remap;

    if (BRIDGE) begin : g_bridge
        assign sec_bus = state_q.image[OFS_SECBUS];
    end else begin : g_endpoint
        assign sec_bus = 8'h00;
    end

endmodule

// File: rtl/cfg_checker.sv
module cfg_checker
    import cfg_pkg::*;
#(
    parameter bit BRIDGE = 1'b0
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        rd_en,
    input logic [7:0]  addr,
    input logic [2:0]  len,
    input logic [7:0]  wbyte,
    input logic [31:0] rdata,
    input logic        remap,
    input logic [7:0]  sec_bus,
    input cfg_image_t  image
);

    // R8: a pulse always traces back to a write strobe
    a_r8_remap_after_write: assert property (@(posedge clk) disable iff (rst)
        remap |-> $past(wr_en));

    // R2: nothing moves without a write
    a_r2_idle_image_stable: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(image));

    // R4: vendor and device identity survive every write
    a_r4_identity_fixed: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> $stable(image[3:0]));

    // R5: type code of the first base register survives every write
    a_r5_bar_type_kept: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> $stable(image[OFS_BAR0][3:0]));

    // R3: reserved command bits stay clear
    a_r3_cmd_reserved_clear: assert property (@(posedge clk) disable iff (rst)
        image[OFS_CMD][7:3] == 5'h0 && image[OFS_CMD + 1] == 8'h00);

    // R1: extended bytes take the written value in full
    a_r1_ext_full_write: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr >= 8'(HDR_BYTES) && len != 3'd0 |=> image[$past(addr)] == $past(wbyte));

    // R9: read data holds between reads
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    // R10: secondary bus number follows a write to its byte
    a_r10_secbus_follow: assert property (@(posedge clk) disable iff (rst)
        BRIDGE && wr_en && addr == 8'(OFS_SECBUS) && len != 3'd0 |=> sec_bus == $past(wbyte));

    // R9: read and write strobes never overlap
    a_r9_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en));

endmodule

bind cfg_space_regfile cfg_checker #(.BRIDGE(BRIDGE)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .len     (len),
    .wbyte   (wdata[7:0]),
    .rdata   (rdata),
    .remap   (remap),
    .sec_bus (sec_bus),
    .image   (image_q)
);

// File: tb/sim_cfg_space_regfile.sv
module sim_cfg_space_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [2:0]  len = 3'd1;
    logic [31:0] wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic        remap0, remap1;
    logic [7:0]  sec0, sec1;

    always #10 clk = ~clk;

    cfg_space_regfile u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .len(len),
        .wdata(wdata), .rdata(rdata0), .remap(remap0), .sec_bus(sec0)
    );

    cfg_space_regfile #(.BRIDGE(1'b1)) u1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .len(len),
        .wdata(wdata), .rdata(rdata1), .remap(remap1), .sec_bus(sec1)
    );

    // Configuration of both instances, restated from the defaults.
    localparam int LG [6]  = '{5, 12, 20, 0, 0, 0};
    localparam int TY [6]  = '{1, 0, 8, 0, 0, 0};
    localparam int ROM_LG  = 11;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] mdl [2][256];
    logic [7:0] msk [2][256];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] size_mask(input int lg, input bit rom);
        if (lg == 0) return 32'h0;
        return (32'hFFFF_FFFF << lg) | (rom ? 32'h1 : 32'h0);
    endfunction

    task automatic build_model();
        for (int k = 0; k < 2; k++) begin
            for (int a = 0; a < 256; a++) begin
                msk[k][a] = (a >= 'h40) ? 8'hFF : 8'h00;
                mdl[k][a] = 8'h00;
            end
            mdl[k]['h00] = 8'hC3; mdl[k]['h01] = 8'hA5;
            mdl[k]['h02] = 8'h02; mdl[k]['h03] = 8'h01;
            mdl[k]['h08] = 8'h07;
            mdl[k]['h09] = 8'h00; mdl[k]['h0A] = 8'h80; mdl[k]['h0B] = 8'h02;
            mdl[k]['h0E] = (k == 1) ? 8'h01 : 8'h00;
            mdl[k]['h3D] = 8'h01;
            msk[k]['h04] = 8'h07;
            msk[k]['h0C] = 8'hFF;
            msk[k]['h3C] = 8'hFF;
            for (int b = 0; b < ((k == 1) ? 2 : 6); b++) begin
                logic [31:0] m;
                m = size_mask(LG[b], 1'b0);
                for (int j = 0; j < 4; j++) msk[k]['h10 + 4*b + j] = m[8*j +: 8];
                if (LG[b] != 0) mdl[k]['h10 + 4*b] = 8'(TY[b]);
            end
            if (k == 1) for (int j = 'h18; j <= 'h1A; j++) msk[k][j] = 8'hFF;
            begin
                logic [31:0] r;
                int base;
                r = size_mask(ROM_LG, 1'b1);
                base = (k == 1) ? 'h38 : 'h30;
                for (int j = 0; j < 4; j++) msk[k][base + j] = r[8*j +: 8];
            end
        end
    endtask

    function automatic string region_req(input int a);
        if (a >= 'h40) return "R1";
        if (a >= 'h10 && a <= 'h27) return "R5";
        if (a >= 'h30 && a <= 'h3B && a != 'h3C) return "R6";
        return "R3";
    endfunction

    task automatic do_write(input int a, input int l, input logic [31:0] d, input string req);
        logic [7:0] old [2][256];
        logic       exp_rm [2];
        old = mdl;
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < l; i++) begin
                if (a + i < 256)
                    mdl[k][a+i] = (mdl[k][a+i] & ~msk[k][a+i]) | (d[8*i +: 8] & msk[k][a+i]);
            end
            exp_rm[k] = |((old[k]['h04] ^ mdl[k]['h04]) & 8'h03);
            for (int j = 'h10; j <= 'h27; j++) if (old[k][j] != mdl[k][j]) exp_rm[k] = 1'b1;
        end
        @(negedge clk);
        wr_en = 1'b1; addr = 8'(a); len = 3'(l); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk({req, " R8 remap endpoint"}, {31'h0, remap0}, {31'h0, exp_rm[0]});
        chk({req, " R8 remap bridge"}, {31'h0, remap1}, {31'h0, exp_rm[1]});
        chk("R10 sec_bus bridge", {24'h0, sec1}, {24'h0, mdl[1]['h19]});
    endtask

    task automatic do_read(input int a, input int l, input string req);
        logic [31:0] e0, e1;
        e0 = '0; e1 = '0;
        for (int i = 0; i < l; i++) begin
            if (a + i < 256) begin
                e0[8*i +: 8] = mdl[0][a+i];
                e1[8*i +: 8] = mdl[1][a+i];
            end
        end
        @(negedge clk);
        rd_en = 1'b1; addr = 8'(a); len = 3'(l);
        @(negedge clk);
        rd_en = 1'b0;
        chk({req, " R9 read endpoint"}, rdata0, e0);
        chk({req, " R9 read bridge"}, rdata1, e1);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        build_model();
    endtask

    initial begin
        build_model();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R11: outputs after reset
        chk("R11 rdata reset", rdata0, 32'h0);
        chk("R11 remap reset", {31'h0, remap0}, 32'h0);
        chk("R10 sec_bus endpoint idle", {24'h0, sec0}, 32'h0);
        // R4: reset image, byte by byte
        for (int a = 0; a < 256; a++) do_read(a, 1, "R4 reset image");

        // single-byte sweep, patterned data
        for (int a = 0; a < 256; a++) begin
            do_write(a, 1, 32'((a * 37 + 5) & 'hFF), region_req(a));
            do_read(a, 1, region_req(a));
        end
        // four-byte sweep of all ones, including lanes past 0xFF
        for (int a = 0; a < 256; a++) begin
            do_write(a, 4, 32'hFFFF_FFFF, "R2");
            do_read(a, 4, "R2");
        end
        // two-byte sweep of zeros
        for (int a = 0; a < 256; a++) begin
            do_write(a, 2, 32'h0000_0000, "R2");
            do_read(a, 2, "R2");
        end

        // R11: reset restores the image after the sweeps
        apply_reset();
        do_read('h10, 4, "R11 bar0 restored");
        do_read('h00, 4, "R11 identity restored");
        do_read('h04, 2, "R11 command restored");

        // R7: one byte of base register 1
        do_write('h15, 1, 32'h0000_00AB, "R7");
        do_read('h14, 4, "R7 only byte 0x15");
        do_write('h15, 1, 32'h0000_00AB, "R7 repeat no change");
        // R8: bus master toggles alone, then decode enables
        do_write('h04, 1, 32'h0000_0004, "R8 master only");
        do_write('h04, 1, 32'h0000_0007, "R8 decode on");
        do_write('h04, 2, 32'hFFFF_0007, "R8 same value");
        // R6: ROM base with enable bit
        do_write('h30, 4, 32'hFFFF_FFFF, "R6");
        do_read('h30, 4, "R6 rom endpoint");
        do_write('h38, 4, 32'hFFFF_FFFF, "R6");
        do_read('h38, 4, "R6 rom bridge");
        // R10: bus numbers
        do_write('h18, 4, 32'h0012_3C01, "R10");
        chk("R10 sec_bus value", {24'h0, sec1}, 32'h3C);
        chk("R10 sec_bus endpoint", {24'h0, sec0}, 32'h0);
        do_read('h18, 4, "R10 bus bytes");
        // R9: reads at the top of the space
        do_write('hFE, 4, 32'hDDCC_BBAA, "R2 top");
        do_read('hFE, 4, "R9 top");
        do_read('hFF, 2, "R9 last byte");
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule